// File: doc/BRIEF.md
# Boot Strap Latch and Program Fetch Map Controller

This block fixes the chip's boot configuration when reset is released. On the first rising clock edge after the active-low reset goes high, it captures three strap inputs: the external-boot request, the flash-secured status and the wide-external-address strap. From these it derives a reset-latched mode bit and a software-writable map bit, and it holds them in a small operating-mode register. A secured flash always forces internal boot, whatever the boot request says. The straps are not looked at again until the next reset.

During normal operation, software reads the operating-mode register and may write its map bit. That write takes effect only when the chip came out of reset in external-boot mode. Each program fetch is steered either to internal program memory or to the external memory interface, according to the effective map bit. The block also drives the reset vector choice, the enable for the external debug port, and a select that turns four general-purpose pins into the upper address lines A[19:16].

Top module: `boot_map_ctrl`

## Requirements
- R1: While `rst_n` is low, `reg_rdata_o` is 0, `debug_en_o` is 0, `hi_addr_sel_o` is 0, `reset_vec_o` equals `VEC_INT`, and no fetch is sent to external memory.
- R2: If `flash_secured_i` is 1 at the capture edge, the mode bit (register bit 1) and the map bit (register bit 0) both load 0, `debug_en_o` stays 0 and `hi_addr_sel_o` stays 0, even when `boot_ext_i` is 1.
- R3: If the flash is not secured and `boot_ext_i` is 0 at the capture edge, both register bits load 0, `debug_en_o` becomes 1, `hi_addr_sel_o` is 0 and `reset_vec_o` is `VEC_INT`.
- R4: If the flash is not secured and `boot_ext_i` is 1 at the capture edge, both register bits load 1 and `debug_en_o` becomes 1. `hi_addr_sel_o` is all ones and `reset_vec_o` is `VEC_EXT_WIDE` when `emi_wide_i` was 1; otherwise `hi_addr_sel_o` is 0 and `reset_vec_o` is `VEC_EXT_NARROW`.
- R5: Straps are captured only on the first rising edge after reset release. Later strap changes alter no output until the next reset.
- R6: When the mode bit is 1, a write with `reg_we_i`=1 loads `reg_wdata_i[0]` into the map bit, and the new value is visible after that edge.
- R7: When the mode bit is 0, writes leave the map bit at 0. A write in the capture cycle is also ignored.
- R8: The mode bit is read-only, and register bits other than 0 and 1 always read 0.
- R9: `fetch_ext_o` is 1 only when `fetch_valid_i`, the map bit and the mode bit are all 1. `fetch_int_o` equals `fetch_valid_i` with `fetch_ext_o` low, and both outputs are 0 when no fetch is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boot_ext_i | input | 1 | Strap: external boot requested |
| flash_secured_i | input | 1 | Flash security status |
| emi_wide_i | input | 1 | Strap: wide external address (upper lines on GPIO) |
| reg_we_i | input | 1 | Operating-mode register write enable |
| reg_wdata_i | input | OMR_W | Register write data |
| reg_rdata_o | output | OMR_W | Register read data (bit 0 map, bit 1 mode) |
| fetch_valid_i | input | 1 | A program fetch is presented |
| fetch_ext_o | output | 1 | Fetch routed to the external memory interface (program strobe) |
| fetch_int_o | output | 1 | Fetch routed to internal program memory |
| debug_en_o | output | 1 | External debug port enable |
| hi_addr_sel_o | output | HI_LINES | Per-pin select of GPIO as upper address line |
| reset_vec_o | output | AW | Selected reset vector address |

## Verification
The assertions take for granted that reset is asserted and released away from a rising clock edge, and that the strap inputs are stable across the capture edge. They also assume the write enable and write data carry known values on every edge. The stimulus changes all inputs on the falling clock edge, including reset itself. Strap changes made after capture serve only to show that they are ignored, and writes in the capture cycle are applied on purpose so the lockout can be seen.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

  typedef struct packed {
    logic done;      // straps have been captured since reset
    logic secured;   // flash security at capture
    logic ext_mode;  // reset-latched mode bit
    logic wide;      // wide external addressing granted
  } strap_state_t;

  localparam int unsigned MAP_BIT_POS  = 0;
  localparam int unsigned MODE_BIT_POS = 1;

endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import boot_map_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         boot_ext_i,
  input  logic         flash_secured_i,
  input  logic         emi_wide_i,
  output strap_state_t state_o,
  output logic         capture_o
);

  strap_state_t st_q, st_d;
  logic         cap_en;

  assign cap_en = ~st_q.done;

  always_comb begin
    st_d = st_q;
    if (cap_en) begin
      st_d.done     = 1'b1;
      st_d.secured  = flash_secured_i;
      st_d.ext_mode = boot_ext_i & ~flash_secured_i;
      st_d.wide     = boot_ext_i & ~flash_secured_i & emi_wide_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (cap_en) begin
      st_q <= st_d;
    end
  end

  assign state_o   = st_q;
  assign capture_o = cap_en;

endmodule

// File: rtl/map_bit_reg.sv
module map_bit_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic strap_mode_i,
  input  logic mode_q_i,
  input  logic we_i,
  input  logic wbit_i,
  output logic map_o
);

  logic map_q, map_d, map_en;

  always_comb begin
    map_en = 1'b0;
    map_d  = map_q;
    if (capture_i) begin
      map_en = 1'b1;
      map_d  = strap_mode_i;
    end else if (we_i && mode_q_i) begin
      map_en = 1'b1;
      map_d  = wbit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= 1'b0;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/fetch_router.sv
module fetch_router (
  input  logic valid_i,
  input  logic map_i,
  input  logic mode_i,
  output logic ext_o,
  output logic int_o
);

  logic go_ext;

  always_comb begin
    go_ext = map_i & mode_i;
    ext_o  = valid_i & go_ext;
    int_o  = valid_i & ~go_ext;
  end

endmodule

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl
  import boot_map_pkg::*;
#(
  parameter int unsigned OMR_W          = 8,
  parameter int unsigned MA_POS         = MAP_BIT_POS,
  parameter int unsigned MB_POS         = MODE_BIT_POS,
  parameter int unsigned HI_LINES       = 4,
  parameter int unsigned AW             = 24,
  parameter logic [AW-1:0] VEC_INT        = 24'h000000,
  parameter logic [AW-1:0] VEC_EXT_NARROW = 24'h00FF00,
  parameter logic [AW-1:0] VEC_EXT_WIDE   = 24'h0F0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_ext_i,
  input  logic                flash_secured_i,
  input  logic                emi_wide_i,
  input  logic                reg_we_i,
  input  logic [OMR_W-1:0]    reg_wdata_i,
  output logic [OMR_W-1:0]    reg_rdata_o,
  input  logic                fetch_valid_i,
  output logic                fetch_ext_o,
  output logic                fetch_int_o,
  output logic                debug_en_o,
  output logic [HI_LINES-1:0] hi_addr_sel_o,
  output logic [AW-1:0]       reset_vec_o
);

  strap_state_t st;
  logic         capture;
  logic         map_bit;
  logic         strap_mode;

  assign strap_mode = boot_ext_i & ~flash_secured_i;

  strap_capture u_strap (
    .clk             (clk),
    .rst_n           (rst_n),
    .boot_ext_i      (boot_ext_i),
    .flash_secured_i (flash_secured_i),
    .emi_wide_i      (emi_wide_i),
    .state_o         (st),
    .capture_o       (capture)
  );

  map_bit_reg u_map (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_i    (capture),
    .strap_mode_i (strap_mode),
    .mode_q_i     (st.ext_mode),
    .we_i         (reg_we_i),
    .wbit_i       (reg_wdata_i[MA_POS]),
    .map_o        (map_bit)
  );

  fetch_router u_route (
    .valid_i (fetch_valid_i),
    .map_i   (map_bit),
    .mode_i  (st.ext_mode),
    .ext_o   (fetch_ext_o),
    .int_o   (fetch_int_o)
  );

  for (genvar b = 0; b < OMR_W; b++) begin : g_rd
    if (b == MA_POS) begin : g_ma
      assign reg_rdata_o[b] = map_bit;
    end else if (b == MB_POS) begin : g_mb
      assign reg_rdata_o[b] = st.ext_mode;
    end else begin : g_zero
      assign reg_rdata_o[b] = 1'b0;
    end
  end

  for (genvar p = 0; p < HI_LINES; p++) begin : g_hi
    assign hi_addr_sel_o[p] = st.wide;
  end

  assign debug_en_o = st.done & ~st.secured;

  always_comb begin
    if (!st.ext_mode)  reset_vec_o = VEC_INT;
    else if (st.wide)  reset_vec_o = VEC_EXT_WIDE;
    else               reset_vec_o = VEC_EXT_NARROW;
  end

endmodule

// File: rtl/boot_map_ctrl_chk.sv
module boot_map_ctrl_chk #(
  parameter int unsigned OMR_W    = 8,
  parameter int unsigned MA_POS   = 0,
  parameter int unsigned MB_POS   = 1,
  parameter int unsigned HI_LINES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we_i,
  input logic [OMR_W-1:0]    reg_wdata_i,
  input logic [OMR_W-1:0]    reg_rdata_o,
  input logic                fetch_valid_i,
  input logic                fetch_ext_o,
  input logic                fetch_int_o,
  input logic                debug_en_o,
  input logic [HI_LINES-1:0] hi_addr_sel_o
);

  // R1: outputs held safe while reset is low
  assert_reset_safe_R1: assert property (@(posedge clk)
    !rst_n |-> (reg_rdata_o == '0) && !debug_en_o && !fetch_ext_o && (hi_addr_sel_o == '0));

  // R2/R4: an external mode bit implies unsecured flash, hence debug on
  assert_mode_implies_unsecured_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[MB_POS] |-> debug_en_o);

  // R4: upper address pins only in external mode
  assert_hi_sel_needs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_addr_sel_o != '0) |-> reg_rdata_o[MB_POS]);

  // R5: once captured, the mode bit does not move
  assert_mode_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(debug_en_o) |-> $stable(reg_rdata_o[MB_POS]));

  // R6: a write with mode set lands in the map bit
  assert_map_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_rdata_o[MB_POS]) |=> (reg_rdata_o[MA_POS] == $past(reg_wdata_i[MA_POS])));

  // R7: map bit locked to 0 while mode is 0
  assert_map_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[MB_POS] |-> !reg_rdata_o[MA_POS]);

  // R9: external routing only with valid fetch and both bits set
  assert_ext_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ext_o |-> fetch_valid_i && reg_rdata_o[MA_POS] && reg_rdata_o[MB_POS]);

  // R9: exactly one destination per valid fetch
  assert_one_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fetch_ext_o, fetch_int_o}) == (fetch_valid_i ? 1 : 0));

endmodule

bind boot_map_ctrl boot_map_ctrl_chk #(
  .OMR_W(OMR_W), .MA_POS(MA_POS), .MB_POS(MB_POS), .HI_LINES(HI_LINES)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we_i      (reg_we_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .fetch_valid_i (fetch_valid_i),
  .fetch_ext_o   (fetch_ext_o),
  .fetch_int_o   (fetch_int_o),
  .debug_en_o    (debug_en_o),
  .hi_addr_sel_o (hi_addr_sel_o)
);

// File: tb/boot_map_ctrl_tb_top.sv
module boot_map_ctrl_tb_top;

  localparam int OMR_W = 8;
  localparam int HI    = 4;
  localparam int AW    = 24;
  localparam logic [AW-1:0] V_INT = 24'h000000;
  localparam logic [AW-1:0] V_NAR = 24'h00FF00;
  localparam logic [AW-1:0] V_WID = 24'h0F0000;

  logic clk = 1'b0;
  logic rst_n, boot_ext, fsec, wide, we, fvalid;
  logic [OMR_W-1:0] wdata, rdata;
  logic fext, fint, dbg;
  logic [HI-1:0] hsel;
  logic [AW-1:0] rvec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit cmp_on = 1'b0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  boot_map_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .boot_ext_i(boot_ext), .flash_secured_i(fsec),
    .emi_wide_i(wide), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fetch_valid_i(fvalid), .fetch_ext_o(fext), .fetch_int_o(fint),
    .debug_en_o(dbg), .hi_addr_sel_o(hsel), .reset_vec_o(rvec)
  );

  // behavioural reference
  bit m_got, m_sec, m_mode, m_map, m_wide;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_got <= 0; m_sec <= 0; m_mode <= 0; m_map <= 0; m_wide <= 0;
    end else if (!m_got) begin
      m_got  <= 1;
      m_sec  <= fsec;
      m_mode <= boot_ext && !fsec;
      m_map  <= boot_ext && !fsec;
      m_wide <= boot_ext && !fsec && wide;
    end else if (we && m_mode) begin
      m_map <= wdata[0];
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%0h expected=%0h @%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      logic [OMR_W-1:0] e_rd;
      logic [AW-1:0] e_vec;
      e_rd = '0;
      e_rd[0] = m_map;
      e_rd[1] = m_mode;
      e_vec = !m_mode ? V_INT : (m_wide ? V_WID : V_NAR);
      chk("rdata R6/R7/R8", rdata, e_rd);
      chk("fetch_ext R9", fext, fvalid && m_map && m_mode);
      chk("fetch_int R9", fint, fvalid && !(m_map && m_mode));
      chk("debug_en R2/R3", dbg, m_got && !m_sec);
      chk("hi_sel R4", hsel, m_wide ? {HI{1'b1}} : '0);
      chk("reset_vec R4", rvec, e_vec);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boot(input bit e, input bit s, input bit w, input bit we_at_cap);
    @(negedge clk);
    rst_n = 0; boot_ext = e; fsec = s; wide = w; we = 0;
    cyc(3);
    rst_n = 1; we = we_at_cap; wdata = 8'h01;   // R7: write in capture cycle ignored
    cyc(1);
    we = 0;
    cyc(2);
  endtask

  task automatic wr(input logic [OMR_W-1:0] d);
    we = 1; wdata = d; cyc(1); we = 0; cyc(1);
  endtask

  task automatic fetches(input int n);
    for (int i = 0; i < n; i++) begin
      fvalid = i[0]; cyc(1);
    end
    fvalid = 0;
  endtask

  initial begin
    rst_n = 1; boot_ext = 1; fsec = 0; wide = 1; we = 0; wdata = 0; fvalid = 0;
    #1 rst_n = 0;
    cmp_on = 1;
    phase = "R1 reset held";
    fvalid = 1; cyc(4); fvalid = 0;

    phase = "R3 internal boot";
    boot(0, 0, 1, 1);
    fetches(4);
    phase = "R7 locked write";
    wr(8'hFF); fetches(3);

    phase = "R2 secured boot";
    boot(1, 1, 1, 1);
    fetches(4);
    wr(8'h01); fetches(2);

    phase = "R4 narrow ext boot";
    boot(1, 0, 0, 1);
    fetches(4);
    phase = "R6 map write";
    wr(8'h00); fetches(3);
    wr(8'h01); fetches(3);
    phase = "R8 ro bits";
    wr(8'hFC); fetches(2);
    wr(8'hFF); fetches(2);
    phase = "R5 strap change ignored";
    boot_ext = 0; fsec = 1; wide = 1; cyc(4); fetches(4);

    phase = "R4 wide ext boot";
    boot(1, 0, 1, 0);
    fetches(6);
    phase = "R9 routing";
    wr(8'h00); fetches(4);
    wr(8'h01); fvalid = 1; cyc(3); fvalid = 0; cyc(2);

    phase = "R1 reset mid-run";
    @(negedge clk); rst_n = 0; fvalid = 1; cyc(3); fvalid = 0;
    rst_n = 1; cyc(3);

    cmp_on = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL [watchdog] run hung actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule